// File: doc/BRIEF.md
# Transmit Duration Fail-Safe Monitor

This block sits between a serial bus terminal's Manchester encoder and its line transmitter. It watches the complementary pair of transmit data lines and times how long one continuous transmission lasts. Short idle gaps do not end a transmission. When a transmission runs past the allowed length, the block sets a sticky fail-safe flag. It then holds both transmit data outputs low and keeps them low until a qualified clear event arrives. The same flag is also driven out as a transmitter inhibit.

A transmission is measured in clock cycles. With the defaults the clock is 12 MHz for a 1 MHz bus, so the limit is 9216 cycles (768 us) and the tolerated gap is 36 cycles (3 us).

The flag can be cleared in two ways:
- a strobe saying that a valid command word addressed to this terminal was received;
- the falling edge of the active-low master reset.

A master reset pulse only clears the flag. It leaves the duration count alone, so a pulse cannot be used to extend a transmission that is already running.

Top module: `txfs_monitor`

## Requirements
- R1: After synchronous reset `rst`, `fail_flag` and `tx_inhibit` are 0 and each data output equals its data input.
- R2: The line is active in any cycle where either data input is 1. While `fail_flag` is 0, `tx_pos_out` equals `tx_pos_in` and `tx_neg_out` equals `tx_neg_in`.
- R3: A transmission of exactly LIMIT_CYC (default 9216) consecutive active cycles does not set `fail_flag`.
- R4: The clock edge of active cycle LIMIT_CYC+1 of one transmission sets `fail_flag`, and `tx_inhibit` equals `fail_flag` at all times.
- R5: While `fail_flag` is 1, both data outputs are 0 whatever the data inputs are.
- R6: An idle gap of GAP_CYC (default 36) cycles or fewer does not end a transmission, and the gap cycles count toward its duration.
- R7: An idle gap of GAP_CYC+1 cycles ends the transmission, and the next one starts counting from zero.
- R8: Once set, `fail_flag` stays 1 through idle time and new traffic until a clear event.
- R9: A 1-to-0 transition of `mrst_n` clears `fail_flag` at that edge. Holding `mrst_n` low has no further clearing effect.
- R10: A master reset pulse does not restart or shorten the duration count of a transmission in progress.
- R11: `cmd_hit` high at an edge clears `fail_flag`. A clear event wins over a trip in the same cycle.
- R12: The duration count saturates at LIMIT_CYC. If a cleared flag sees the same transmission still active, the flag is set again at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (12 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| tx_pos_in | input | 1 | Raw true-polarity transmit data |
| tx_neg_in | input | 1 | Raw complement-polarity transmit data |
| mrst_n | input | 1 | Active-low master reset; its falling edge clears the flag |
| cmd_hit | input | 1 | Strobe: valid command word for this terminal received |
| tx_pos_out | output | 1 | Gated true-polarity transmit data |
| tx_neg_out | output | 1 | Gated complement-polarity transmit data |
| fail_flag | output | 1 | Latched fail-safe flag |
| tx_inhibit | output | 1 | Transmitter inhibit, a copy of the flag |

## Verification
The bench goes after the exact limit edge in two ways: LIMIT_CYC active cycles must not trip, and one more must. An off-by-one counter would fire a cycle early or a cycle late.

It also covers both sides of the gap tolerance. A design that counted only active cycles, or cut the gap one cycle short, would trip at the wrong cycle after a 36-cycle gap, or fail to restart after 37 idle cycles.

A master reset pulse is placed inside a long transmission. A design that let the pulse clear the counter would miss the trip.

A master reset held low, and a clear in the same cycle as a pending trip, are both applied to a saturated counter. A level-sensitive clear would keep the outputs open. A design without saturation, or without clear priority, would not show the clear-then-retrip sequence.

// File: rtl/txfs_pkg.sv
package txfs_pkg;

    // Complementary transmit data pair
    typedef struct packed {
        logic pos;
        logic neg;
    } tx_pair_t;

    // Line activity tracking state
    typedef enum logic [1:0] {
        LINE_IDLE = 2'd0,
        LINE_BUSY = 2'd1,
        LINE_GAP  = 2'd2
    } line_state_t;

    // The line is driven whenever either half of the pair is high
    function automatic logic pair_active(input tx_pair_t p);
        return p.pos | p.neg;
    endfunction

    // Force both halves low when blocked
    function automatic tx_pair_t pair_gate(input tx_pair_t p, input logic blk);
        tx_pair_t r;
        r.pos = p.pos & ~blk;
        r.neg = p.neg & ~blk;
        return r;
    endfunction

endpackage

// File: rtl/txfs_gap_track.sv
module txfs_gap_track
    import txfs_pkg::*;
#(
    parameter int unsigned GAP_CYC = 36
) (
    input  logic     clk,
    input  logic     rst,
    input  tx_pair_t line,
    output logic     active,
    output logic     burst_end,
    output logic     count_en
);

    localparam int unsigned     GW      = $clog2(GAP_CYC + 2);
    localparam logic [GW-1:0]   GAP_MAX = GW'(GAP_CYC);
    localparam logic [GW-1:0]   GAP_SAT = GW'(GAP_CYC + 1);

    logic [GW-1:0] gap_q, gap_d;
    line_state_t   st_q, st_d;

    always_comb begin
        active    = pair_active(line);
        // The idle cycle after GAP_CYC idle cycles closes the transmission
        burst_end = !active && (gap_q == GAP_MAX);
        // Gap cycles inside a transmission still count toward its length
        count_en  = active || ((st_q != LINE_IDLE) && !burst_end);

        gap_d = gap_q;
        st_d  = st_q;
        if (active) begin
            gap_d = '0;
            st_d  = LINE_BUSY;
        end else begin
            if (gap_q != GAP_SAT) begin
                gap_d = gap_q + 1'b1;
            end
            if (burst_end) begin
                st_d = LINE_IDLE;
            end else if (st_q == LINE_BUSY) begin
                st_d = LINE_GAP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GAP_SAT;
            st_q  <= LINE_IDLE;
        end else begin
            gap_q <= gap_d;
            st_q  <= st_d;
        end
    end

endmodule

// File: rtl/txfs_dur_count.sv
module txfs_dur_count #(
    parameter int unsigned LIMIT_CYC = 9216,
    parameter int unsigned DW        = $clog2(LIMIT_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          count_en,
    input  logic          clr,
    output logic          at_limit,
    output logic [DW-1:0] dur_q
);

    localparam logic [DW-1:0] LIM = DW'(LIMIT_CYC);

    logic [DW-1:0] dur_d;

    always_comb begin
        at_limit = (dur_q == LIM);
        dur_d    = dur_q;
        if (clr) begin
            dur_d = '0;
        end else if (count_en && !at_limit) begin
            dur_d = dur_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dur_q <= '0;
        end else begin
            dur_q <= dur_d;
        end
    end

endmodule

// File: rtl/txfs_trip_latch.sv
module txfs_trip_latch (
    input  logic clk,
    input  logic rst,
    input  logic trip_req,
    input  logic cmd_hit,
    input  logic mrst_n,
    output logic flag_q,
    output logic mrst_fall
);

    logic mrst_q;
    logic clr;
    logic flag_d;

    always_comb begin
        mrst_fall = mrst_q & ~mrst_n;
        clr       = mrst_fall | cmd_hit;
        // A clear event takes priority over a trip in the same cycle
        flag_d    = clr ? 1'b0 : (flag_q | trip_req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mrst_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            mrst_q <= mrst_n;
            flag_q <= flag_d;
        end
    end

endmodule

// File: rtl/txfs_monitor.sv
module txfs_monitor
    import txfs_pkg::*;
#(
    parameter int unsigned LIMIT_CYC = 9216,
    parameter int unsigned GAP_CYC   = 36
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_pos_in,
    input  logic tx_neg_in,
    input  logic mrst_n,
    input  logic cmd_hit,
    output logic tx_pos_out,
    output logic tx_neg_out,
    output logic fail_flag,
    output logic tx_inhibit
);

    localparam int unsigned DUR_W = $clog2(LIMIT_CYC + 1);

    tx_pair_t         raw_pair;
    tx_pair_t         gated_pair;
    logic             line_active;
    logic             burst_end;
    logic             count_en;
    logic             dur_at_limit;
    logic [DUR_W-1:0] dur_cnt;
    logic             trip_req;
    logic             mrst_fall;

    assign raw_pair.pos = tx_pos_in;
    assign raw_pair.neg = tx_neg_in;

    txfs_gap_track #(
        .GAP_CYC (GAP_CYC)
    ) u_gap (
        .clk       (clk),
        .rst       (rst),
        .line      (raw_pair),
        .active    (line_active),
        .burst_end (burst_end),
        .count_en  (count_en)
    );

    txfs_dur_count #(
        .LIMIT_CYC (LIMIT_CYC),
        .DW        (DUR_W)
    ) u_dur (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .clr      (burst_end),
        .at_limit (dur_at_limit),
        .dur_q    (dur_cnt)
    );

    // Still driving after the limit is reached
    assign trip_req = line_active & dur_at_limit;

    txfs_trip_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .trip_req  (trip_req),
        .cmd_hit   (cmd_hit),
        .mrst_n    (mrst_n),
        .flag_q    (fail_flag),
        .mrst_fall (mrst_fall)
    );

    assign gated_pair = pair_gate(raw_pair, fail_flag);
    assign tx_pos_out = gated_pair.pos;
    assign tx_neg_out = gated_pair.neg;
    assign tx_inhibit = fail_flag;

endmodule

// File: rtl/txfs_monitor_chk.sv
module txfs_monitor_chk #(
    parameter int unsigned LIMIT_CYC = 9216,
    parameter int unsigned DW        = 14
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_pos_in,
    input logic          tx_neg_in,
    input logic          tx_pos_out,
    input logic          tx_neg_out,
    input logic          fail_flag,
    input logic          cmd_hit,
    input logic          mrst_fall,
    input logic          line_active,
    input logic          dur_at_limit,
    input logic [DW-1:0] dur_cnt
);

    // R5
    outputs_low_chk: assert property (@(posedge clk) disable iff (rst)
        fail_flag |-> (!tx_pos_out && !tx_neg_out));

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        !fail_flag |-> (tx_pos_out == tx_pos_in && tx_neg_out == tx_neg_in));

    // R4
    trip_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_flag) |-> $past(dur_at_limit && line_active));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_flag && !cmd_hit && !mrst_fall) |=> fail_flag);

    // R11
    cmd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_hit |=> !fail_flag);

    // R9
    mrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mrst_fall |=> !fail_flag);

    // R12
    dur_sat_chk: assert property (@(posedge clk) disable iff (rst)
        dur_cnt <= DW'(LIMIT_CYC));

endmodule

bind txfs_monitor txfs_monitor_chk #(
    .LIMIT_CYC (LIMIT_CYC),
    .DW        (DUR_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_pos_in    (tx_pos_in),
    .tx_neg_in    (tx_neg_in),
    .tx_pos_out   (tx_pos_out),
    .tx_neg_out   (tx_neg_out),
    .fail_flag    (fail_flag),
    .cmd_hit      (cmd_hit),
    .mrst_fall    (mrst_fall),
    .line_active  (line_active),
    .dur_at_limit (dur_at_limit),
    .dur_cnt      (dur_cnt)
);

// File: tb/sim_txfs_monitor.sv
module sim_txfs_monitor;

    localparam int L = 9216;
    localparam int G = 36;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_pos_in = 1'b0;
    logic tx_neg_in = 1'b0;
    logic mrst_n = 1'b1;
    logic cmd_hit = 1'b0;
    logic tx_pos_out, tx_neg_out, fail_flag, tx_inhibit;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        bit    chk;
        logic  ep;
        logic  en;
        logic  ef;
        string req;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    txfs_monitor #(.LIMIT_CYC(L), .GAP_CYC(G)) u0 (
        .clk        (clk),
        .rst        (rst),
        .tx_pos_in  (tx_pos_in),
        .tx_neg_in  (tx_neg_in),
        .mrst_n     (mrst_n),
        .cmd_hit    (cmd_hit),
        .tx_pos_out (tx_pos_out),
        .tx_neg_out (tx_neg_out),
        .fail_flag  (fail_flag),
        .tx_inhibit (tx_inhibit)
    );

    // Driver: apply one cycle of stimulus and queue what the outputs must be after its edge
    task automatic tick(input logic a, input logic b, input logic m, input logic c,
                        input logic ef, input string req);
        exp_t it;
        @(negedge clk);
        tx_pos_in = a;
        tx_neg_in = b;
        mrst_n    = m;
        cmd_hit   = c;
        it.chk = 1'b1;
        it.ef  = ef;
        it.ep  = ef ? 1'b0 : a;
        it.en  = ef ? 1'b0 : b;
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic burst(input int n, input int pat, input logic ef, input string req);
        for (int i = 0; i < n; i++) begin
            if (pat == 0)      tick(i[0], ~i[0], 1'b1, 1'b0, ef, req);
            else if (pat == 1) tick(1'b1, 1'b1, 1'b1, 1'b0, ef, req);
            else               tick(1'b1, 1'b0, 1'b1, 1'b0, ef, req);
        end
    endtask

    task automatic idle(input int n, input logic ef, input string req);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b1, 1'b0, ef, req);
    endtask

    // Monitor: compare after each edge, away from it
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                if (it.chk) begin
                    n_tests++;
                    if ({tx_pos_out, tx_neg_out, fail_flag, tx_inhibit} !==
                        {it.ep, it.en, it.ef, it.ef}) begin
                        n_fail++;
                        $display("FAIL %s: got out=%b%b flag=%b inh=%b, expected out=%b%b flag=%b inh=%b",
                                 it.req, tx_pos_out, tx_neg_out, fail_flag, tx_inhibit,
                                 it.ep, it.en, it.ef, it.ef);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, outputs follow inputs
        tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        tick(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        // R2: either line high passes through
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R2");
        tick(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R2");
        idle(G + 1, 1'b0, "R7");

        // R3: exactly the limit does not trip; R4: one more does
        burst(L, 0, 1'b0, "R3");
        tick(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
        // R5: outputs blocked
        burst(5, 1, 1'b1, "R5");
        // R8: flag latched through idle and new traffic
        idle(G + 5, 1'b1, "R8");
        burst(3, 2, 1'b1, "R5");
        idle(G + 1, 1'b1, "R8");
        // R9: master reset falling edge clears
        tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9");

        // R6: 36-cycle gap is continuous and counted: 5000 + 36 + 4180 = L
        burst(5000, 0, 1'b0, "R6");
        idle(G, 1'b0, "R6");
        burst(4180, 2, 1'b0, "R6");
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
        idle(G + 1, 1'b1, "R8");
        tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9");

        // R7: 37-cycle gap restarts the count
        burst(5000, 0, 1'b0, "R7");
        idle(G + 1, 1'b0, "R7");
        burst(L, 1, 1'b0, "R7");
        tick(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
        idle(G + 1, 1'b1, "R8");
        // R11: command strobe clears
        tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R11");
        idle(1, 1'b0, "R11");

        // R10: master reset pulse mid-transmission keeps the count
        burst(3000, 0, 1'b0, "R10");
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R10");
        burst(L - 3002, 0, 1'b0, "R10");
        tick(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
        // R9: falling edge clears once; held low does not; R12: saturated re-trip
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R12");
        tick(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R9");
        // R11: clear wins over a same-cycle trip, then R12 re-trip
        tick(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R11");
        tick(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R12");
        idle(G + 1, 1'b1, "R8");
        tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R11");
        idle(2, 1'b0, "R1");

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule